// File: doc/BRIEF.md
# Lane Routing and Squelch Controller

This block holds the digital data-path control of a four-lane serial repeater. The lanes are grouped in two pairs, pair A (lanes A0, A1) and pair B (lanes B0, B1). A 2-bit route code picks one of three routing plans from the four inputs to the four outputs. In fan-out, lane 0 of a pair feeds both outputs of that pair. In straight-through, every input feeds its own output. In crossed, lane 0 feeds the lane 1 output and the lane 0 output carries no data.

Each output is in one of three states. It is driven, squelched (quiet at common mode, modelled as all-zero data), or inactive (high impedance). The state depends on a global power-down input, a receiver-present flag per pair, the route plan, and the idle flag of the input routed to that output. Output data and output state are both registered. They follow the inputs with exactly one clock of latency.

Lane data are symbols of `DATA_W` bits. Bus lanes are indexed 0 = A0, 1 = A1, 2 = B0, 3 = B1.

Top module: `lane_route_ctrl`

## Requirements
- R1: While reset is asserted, and at the first clock after it, every output state is inactive (00) and every output carries zero data.
- R2: Route codes 01 and 11 select straight-through: each input feeds the output of the same lane.
- R3: Route code 00 selects fan-out: input A0 feeds outputs A0 and A1, and input B0 feeds outputs B0 and B1. The data and idle flags of inputs A1 and B1 have no effect.
- R4: Route code 10 selects crossed: input A0 feeds output A1 and input B0 feeds output B1. Outputs A0 and B0 are squelched. Inputs A1 and B1 have no effect.
- R5: An output whose routed input has its idle flag set is squelched.
- R6: When the receiver-present flag of a pair is clear (bit 0 = pair A, bit 1 = pair B), both outputs of that pair are inactive, whatever the route code and idle flags.
- R7: When power-down is high, all four outputs are inactive, whatever the other inputs.
- R8: Output state and data reflect the inputs sampled at the previous rising clock edge: one register stage, no combinational path.
- R9: Priority and encoding. Power-down wins over a missing receiver, which wins over squelch. State codes are inactive = 00, squelched = 01, driven = 10, and 11 never appears. An output that is not driven carries zero data. Lane i uses `lane_state[2i+1:2i]` and `lane_out[i*DATA_W +: DATA_W]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_sel | input | 2 | Route code: 00 fan-out, 01/11 straight-through, 10 crossed |
| pwr_dn | input | 1 | Global power-down, forces all outputs inactive |
| rx_present | input | 2 | Receiver detected, bit 0 pair A, bit 1 pair B |
| idle | input | 4 | Electrical-idle flag per input lane |
| lane_in | input | 4*DATA_W | Input lane symbols |
| lane_out | output | 4*DATA_W | Registered output lane symbols |
| lane_state | output | 8 | Registered 2-bit state per output lane |

## Verification
The hardest case to reach is an input that must be ignored. Lane 1 inputs in fan-out and crossed modes, and the idle flag of an input that is not routed anywhere, only show up as a missing change at an output. The bench sweeps all 512 combinations of route code, receiver flags, power-down and idle flags, with fresh lane data on every step. A directed task then holds lane 0 steady while it toggles only the lane 1 data and idle flag, and confirms that the outputs stay frozen.

// File: rtl/lrc_pkg.sv
package lrc_pkg;
    localparam int NUM_LANES = 4;
    localparam int NUM_PAIRS = NUM_LANES / 2;

    typedef enum logic [1:0] {
        RT_FANOUT   = 2'b00,
        RT_STRAIGHT = 2'b01,
        RT_CROSSED  = 2'b10
    } route_e;

    typedef enum logic [1:0] {
        LS_HIZ     = 2'b00,
        LS_SQUELCH = 2'b01,
        LS_ACTIVE  = 2'b10
    } lane_st_e;
endpackage

// File: rtl/lrc_mode_decode.sv
module lrc_mode_decode
    import lrc_pkg::*;
(
    input  logic [1:0] code_i,
    output route_e     route_o
);
    always_comb begin
        unique case (code_i)
            2'b00:   route_o = RT_FANOUT;
            2'b10:   route_o = RT_CROSSED;
            default: route_o = RT_STRAIGHT;  // 01 and 11
        endcase
    end
endmodule

// File: rtl/lrc_pair_route.sv
module lrc_pair_route
    import lrc_pkg::*;
#(
    parameter int DATA_W = 4
) (
    input  route_e                 route_i,
    input  logic                   pwr_dn_i,
    input  logic                   rx_ok_i,
    input  logic [1:0]             idle_i,
    input  logic [1:0][DATA_W-1:0] din_i,
    output lane_st_e [1:0]         st_o,
    output logic [1:0][DATA_W-1:0] dout_o
);
    for (genvar k = 0; k < 2; k++) begin : g_out
        localparam logic POS = (k == 1);
        logic src;
        logic src_vld;

        always_comb begin
            src     = POS;
            src_vld = 1'b1;
            case (route_i)
                RT_FANOUT:  src = 1'b0;
                RT_CROSSED: begin
                    src     = 1'b0;
                    src_vld = POS;
                end
                default:    src = POS;
            endcase
        end

        always_comb begin
            st_o[k]   = LS_ACTIVE;
            dout_o[k] = din_i[src];
            if (pwr_dn_i || !rx_ok_i) begin
                st_o[k]   = LS_HIZ;
                dout_o[k] = '0;
            end else if (!src_vld || idle_i[src]) begin
                st_o[k]   = LS_SQUELCH;
                dout_o[k] = '0;
            end
        end
    end
endmodule

// File: rtl/lane_route_ctrl.sv
module lane_route_ctrl
    import lrc_pkg::*;
#(
    parameter int DATA_W = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [1:0]                    mode_sel,
    input  logic                          pwr_dn,
    input  logic [NUM_PAIRS-1:0]          rx_present,
    input  logic [NUM_LANES-1:0]          idle,
    input  logic [NUM_LANES*DATA_W-1:0]   lane_in,
    output logic [NUM_LANES*DATA_W-1:0]   lane_out,
    output logic [2*NUM_LANES-1:0]        lane_state
);
    typedef struct packed {
        logic [NUM_LANES-1:0][DATA_W-1:0] data;
        lane_st_e [NUM_LANES-1:0]         st;
    } out_s;

    route_e                           route;
    logic [NUM_LANES-1:0][DATA_W-1:0] din;
    logic [NUM_LANES-1:0][DATA_W-1:0] rt_data;
    lane_st_e [NUM_LANES-1:0]         rt_st;
    out_s                             out_d, out_q;

    assign din = lane_in;

    lrc_mode_decode i_dec (
        .code_i  (mode_sel),
        .route_o (route)
    );

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        lrc_pair_route #(.DATA_W(DATA_W)) i_pair (
            .route_i  (route),
            .pwr_dn_i (pwr_dn),
            .rx_ok_i  (rx_present[p]),
            .idle_i   (idle[2*p +: 2]),
            .din_i    (din[2*p +: 2]),
            .st_o     (rt_st[2*p +: 2]),
            .dout_o   (rt_data[2*p +: 2])
        );
    end

    always_comb begin
        out_d      = out_q;
        out_d.data = rt_data;
        out_d.st   = rt_st;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign lane_out   = out_q.data;
    assign lane_state = out_q.st;
endmodule

// File: rtl/lrc_checker.sv
module lrc_checker #(
    parameter int DATA_W = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [1:0]            mode_sel,
    input logic                  pwr_dn,
    input logic [1:0]            rx_present,
    input logic [3:0]            idle,
    input logic [4*DATA_W-1:0]   lane_in,
    input logic [4*DATA_W-1:0]   lane_out,
    input logic [7:0]            lane_state
);
    localparam int W = DATA_W;
    logic seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    // R1: held in reset the outputs stay inactive and zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_reset_quiet_r1: assert (lane_state == 8'h00 && lane_out == '0);
        end
    end

    p_pwrdn_hiz_r7: assert property (@(posedge clk) disable iff (!rst_n || !seen_q)
        $past(pwr_dn) |-> lane_state == 8'h00);

    p_rxa_absent_r6: assert property (@(posedge clk) disable iff (!rst_n || !seen_q)
        $past(!rx_present[0]) |-> lane_state[3:0] == 4'b0000);

    p_rxb_absent_r6: assert property (@(posedge clk) disable iff (!rst_n || !seen_q)
        $past(!rx_present[1]) |-> lane_state[7:4] == 4'b0000);

    p_cross_lane0_r4: assert property (@(posedge clk) disable iff (!rst_n || !seen_q)
        $past(mode_sel == 2'b10 && !pwr_dn && rx_present[0]) |-> lane_state[1:0] == 2'b01);

    p_fanout_copy_r3: assert property (@(posedge clk) disable iff (!rst_n || !seen_q)
        $past(mode_sel == 2'b00 && !pwr_dn && rx_present[0] && !idle[0])
        |-> (lane_out[2*W-1:W] == $past(lane_in[W-1:0]) && lane_state[3:2] == 2'b10));

    p_straight_b1_r2: assert property (@(posedge clk) disable iff (!rst_n || !seen_q)
        $past(mode_sel[0] && !pwr_dn && rx_present[1] && !idle[3])
        |-> lane_out[4*W-1:3*W] == $past(lane_in[4*W-1:3*W]));

    p_idle_squelch_r5: assert property (@(posedge clk) disable iff (!rst_n || !seen_q)
        $past(mode_sel == 2'b01 && !pwr_dn && rx_present[0] && idle[0])
        |-> lane_state[1:0] == 2'b01);

    for (genvar i = 0; i < 4; i++) begin : g_lane
        p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
            lane_state[2*i +: 2] != 2'b10 |-> lane_out[i*W +: W] == '0);
        p_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
            lane_state[2*i +: 2] != 2'b11);
    end
endmodule

bind lane_route_ctrl lrc_checker #(.DATA_W(DATA_W)) i_lrc_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_sel   (mode_sel),
    .pwr_dn     (pwr_dn),
    .rx_present (rx_present),
    .idle       (idle),
    .lane_in    (lane_in),
    .lane_out   (lane_out),
    .lane_state (lane_state)
);

// File: tb/test_lane_route_ctrl.sv
`timescale 1ns/1ps
module test_lane_route_ctrl;
    localparam int W = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [1:0]      mode_sel = 2'b01;
    logic            pwr_dn = 1'b0;
    logic [1:0]      rx_present = 2'b11;
    logic [3:0]      idle = 4'h0;
    logic [4*W-1:0]  lane_in = '0;
    logic [4*W-1:0]  lane_out;
    logic [7:0]      lane_state;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;  // 125 MHz

    lane_route_ctrl #(.DATA_W(W)) i_lane_route_ctrl (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .pwr_dn(pwr_dn),
        .rx_present(rx_present), .idle(idle), .lane_in(lane_in),
        .lane_out(lane_out), .lane_state(lane_state)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Source lane feeding an output, -1 when none (from R2/R3/R4)
    function automatic int ref_src(input int lane, input logic [1:0] m);
        int pos  = lane % 2;
        int base = lane - pos;
        if (m == 2'b00) return base;
        if (m == 2'b10) return (pos == 1) ? base : -1;
        return lane;
    endfunction

    // Expected state from R5/R6/R7/R9
    function automatic logic [1:0] ref_st(input int lane, input logic [1:0] m,
        input logic [3:0] idl, input logic [1:0] rx, input logic pd);
        int s = ref_src(lane, m);
        if (pd) return 2'b00;
        if (!rx[lane/2]) return 2'b00;
        if (s < 0) return 2'b01;
        if (idl[s]) return 2'b01;
        return 2'b10;
    endfunction

    function automatic string ref_tag(input int lane, input logic [1:0] m,
        input logic [3:0] idl, input logic [1:0] rx, input logic pd);
        int s = ref_src(lane, m);
        if (pd) return "R7";
        if (!rx[lane/2]) return "R6";
        if (s < 0) return "R4";
        if (idl[s]) return "R5";
        if (m == 2'b00) return "R3";
        if (m == 2'b10) return "R4";
        return "R2";
    endfunction

    task automatic check_lanes(input logic [1:0] m, input logic [3:0] idl,
        input logic [1:0] rx, input logic pd, input logic [4*W-1:0] din);
        for (int l = 0; l < 4; l++) begin
            logic [1:0]   es = ref_st(l, m, idl, rx, pd);
            int           s  = ref_src(l, m);
            logic [W-1:0] ed = (es == 2'b10) ? din[s*W +: W] : '0;
            string        tg = ref_tag(l, m, idl, rx, pd);
            chk(tg, "state", 32'(lane_state[2*l +: 2]), 32'(es));
            if (es == 2'b10) chk(tg, "data", 32'(lane_out[l*W +: W]), 32'(ed));
            else             chk("R9", "quiet data", 32'(lane_out[l*W +: W]), 32'(ed));
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1", "state in reset", 32'(lane_state), 32'h0);
        chk("R1", "data in reset", 32'(lane_out), 32'h0);
        mode_sel = 2'b01; rx_present = 2'b11; lane_in = 16'hBEEF;
        @(negedge clk);
        chk("R1", "state held in reset", 32'(lane_state), 32'h0);
        rst_n = 1'b1;
        lane_in = 16'h0;
        idle = 4'hF;
        @(negedge clk);
    endtask

    task automatic t_sweep();
        int c = 0;
        for (int m = 0; m < 4; m++)
            for (int rx = 0; rx < 4; rx++)
                for (int pd = 0; pd < 2; pd++)
                    for (int id = 0; id < 16; id++) begin
                        logic [4*W-1:0] d = 16'(c * 16'h9E37 + 16'h1234);
                        mode_sel = 2'(m); rx_present = 2'(rx); pwr_dn = 1'(pd);
                        idle = 4'(id); lane_in = d;
                        @(posedge clk); @(negedge clk);
                        check_lanes(2'(m), 4'(id), 2'(rx), 1'(pd), d);
                        c++;
                    end
    endtask

    task automatic t_latency();
        mode_sel = 2'b01; rx_present = 2'b11; pwr_dn = 1'b0; idle = 4'h0;
        lane_in = 16'hA5C3;
        @(posedge clk); @(negedge clk);
        lane_in = 16'h5A3C;
        #2;
        chk("R8", "data before edge", 32'(lane_out), 32'hA5C3);
        @(posedge clk); #1;
        chk("R8", "data after edge", 32'(lane_out), 32'h5A3C);
        @(negedge clk);
        pwr_dn = 1'b1;
        #2;
        chk("R8", "state before edge", 32'(lane_state), 32'hAA);
        @(posedge clk); #1;
        chk("R8", "state after edge", 32'(lane_state), 32'h00);
        @(negedge clk);
        pwr_dn = 1'b0;
    endtask

    // Lane 1 inputs toggled alone must leave every output unchanged
    task automatic t_ignore(input logic [1:0] m, input string tg);
        logic [4*W-1:0] base_out;
        logic [7:0]     base_st;
        mode_sel = m; rx_present = 2'b11; pwr_dn = 1'b0; idle = 4'h0;
        lane_in = 16'h3C96;
        @(posedge clk); @(negedge clk);
        base_out = lane_out; base_st = lane_state;
        for (int k = 0; k < 4; k++) begin
            lane_in[W +: W]   = 4'(k * 5 + 1);
            lane_in[3*W +: W] = 4'(k * 3 + 7);
            idle[1] = k[0];
            idle[3] = k[1];
            @(posedge clk); @(negedge clk);
            chk(tg, "lane1 input ignored, data", 32'(lane_out), 32'(base_out));
            chk(tg, "lane1 input ignored, state", 32'(lane_state), 32'(base_st));
        end
        idle = 4'h0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R8 watchdog: actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_sweep();
        t_latency();
        t_ignore(2'b00, "R3");
        t_ignore(2'b10, "R4");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule